// File: doc/BRIEF.md
# Video Beam Slot Counter

This block tracks where the video beam is, measured in memory-access slots. One slot is two processor clocks, which is one window for access to chip memory. A slot-enable pulse advances the counter by one. The block reports the slot position within the current line and the line number within the current frame. It raises single-cycle strobes on the last slot of a line and on the last slot of a frame. It also drives a field flag that is used during interlaced scan.

Two standards are supported. In the 60 Hz (NTSC) standard the line lengths alternate: a short line of 227 slots is followed by a long line of 228 slots. The frame has 262 lines. In the 50 Hz (PAL) standard every line has 227 slots and the frame has 312 lines. When interlace is on, every frame with the field flag set is one line longer. The standard and interlace selections are read only at frame boundaries, so a running frame never changes its geometry. All lengths are parameters, which lets a test use small frames.

Top module: `beam_slot_counter`

## Requirements
- R1: After reset the slot index is 0, the line index is 0, the field flag is 0, the current line is short, and the active mode is 60 Hz without interlace.
- R2: The slot index increases by one only on a cycle where `slot_en` is 1. When `slot_en` is 0, every output register keeps its value.
- R3: On an enabled cycle in which the slot index is the last slot of the line, `line_end` is 1. The slot index then returns to 0 and, unless the frame ends, the line index increases by one.
- R4: In 60 Hz mode the first line of every frame is short (227 slots, `line_long`=0). The long/short state inverts at every line end, so a long line (228 slots, `line_long`=1) follows each short line.
- R5: In 50 Hz mode every line has 227 slots, whatever the value of `line_long`.
- R6: A frame has 262 lines in 60 Hz mode and 312 lines in 50 Hz mode. `frame_end` is 1 on the enabled last slot of the last line, and both indices then return to 0.
- R7: While interlace is active, `field_odd` inverts at every frame end, and a frame with `field_odd`=1 has one extra line. When interlace is not active, a frame end clears `field_odd`.
- R8: `pal_sel` (1 = 50 Hz) and `lace_sel` (1 = interlace) are sampled only on a frame end. A change at any other time has no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_en | input | 1 | Advance by one slot |
| pal_sel | input | 1 | Requested standard, 1 = 50 Hz |
| lace_sel | input | 1 | Requested interlace |
| slot_idx | output | SLOT_W | Slot position within the line |
| line_idx | output | LINE_W | Line number within the frame |
| line_end | output | 1 | Strobe on the enabled last slot of a line |
| frame_end | output | 1 | Strobe on the enabled last slot of a frame |
| field_odd | output | 1 | Interlace field flag |
| line_long | output | 1 | The current 60 Hz line is the long one |

## Verification
On the last slot of the last line, the line end and the frame end happen in the same cycle. In that cycle the long/short toggle, the line advance, the mode capture and the field flip all act on one edge. The bench uses small parameters so that this corner occurs many times. It drives `slot_en` with gaps, including a gap placed exactly on a final slot. It also changes `pal_sel` and `lace_sel` in the middle of frames and on the frame-end cycle itself. A behavioural model is compared with the design on every clock, covering both strobes, both indices, the field flag and the line-length flag. This shows whether the combined edge leaves the next frame short-first, at index 0, and in the newly captured mode.

// File: rtl/beam_pkg.sv
package beam_pkg;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/beam_hcount.sv
module beam_hcount #(
    parameter int unsigned NTSC_SHORT = 227,
    parameter int unsigned PAL_SLOTS  = 227,
    parameter int unsigned W          = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slot_en,
    input  logic         pal_act,
    input  logic         frame_wrap,
    output logic [W-1:0] slot,
    output logic         eol,
    output logic         long_now
);

    typedef struct packed {
        logic [W-1:0] slot;
        logic         long_l;
    } hstate_t;

    hstate_t h_d, h_q;
    logic [W-1:0] last_slot;

    always_comb begin
        h_d = h_q;
        if (pal_act)
            last_slot = W'(PAL_SLOTS - 1);
        else if (h_q.long_l)
            last_slot = W'(NTSC_SHORT);
        else
            last_slot = W'(NTSC_SHORT - 1);
        eol = slot_en && (h_q.slot == last_slot);
        if (slot_en) begin
            if (h_q.slot == last_slot) begin
                h_d.slot   = '0;
                h_d.long_l = frame_wrap ? 1'b0 : ~h_q.long_l;
            end else begin
                h_d.slot = h_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign slot     = h_q.slot;
    assign long_now = h_q.long_l;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(h_q));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en && !eol |=> h_q.slot == $past(h_q.slot) + 1'b1);
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> h_q.slot == '0);
    p_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eol && !frame_wrap |=> h_q.long_l != $past(h_q.long_l));
    p_short_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> !h_q.long_l);

endmodule

// File: rtl/beam_vcount.sv
module beam_vcount #(
    parameter int unsigned NTSC_LINES = 262,
    parameter int unsigned PAL_LINES  = 312,
    parameter int unsigned W          = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eol,
    input  logic         pal_sel,
    input  logic         lace_sel,
    output logic [W-1:0] line,
    output logic         eof,
    output logic         field,
    output logic         pal_act
);

    typedef struct packed {
        logic [W-1:0] line;
        logic         field;
        logic         pal;
        logic         lace;
    } vstate_t;

    vstate_t v_d, v_q;
    logic [W-1:0] last_line;

    always_comb begin
        v_d       = v_q;
        last_line = v_q.pal ? W'(PAL_LINES - 1) : W'(NTSC_LINES - 1);
        if (v_q.lace && v_q.field)
            last_line = last_line + 1'b1;
        eof = eol && (v_q.line == last_line);
        if (eol) begin
            if (eof) begin
                v_d.line  = '0;
                v_d.field = v_q.lace ? ~v_q.field : 1'b0;
                v_d.pal   = pal_sel;
                v_d.lace  = lace_sel;
            end else begin
                v_d.line = v_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign line    = v_q.line;
    assign field   = v_q.field;
    assign pal_act = v_q.pal;

    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eol && !eof |=> v_q.line == $past(v_q.line) + 1'b1);
    p_line_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> v_q.line == '0);
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !eof |=> $stable(v_q.pal) && $stable(v_q.lace));
    p_field_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eof && v_q.lace |=> v_q.field != $past(v_q.field));
    p_field_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eof && !v_q.lace |=> !v_q.field);

endmodule

// File: rtl/beam_slot_counter.sv
module beam_slot_counter
    import beam_pkg::*;
#(
    parameter int unsigned NTSC_SHORT = 227,
    parameter int unsigned PAL_SLOTS  = 227,
    parameter int unsigned NTSC_LINES = 262,
    parameter int unsigned PAL_LINES  = 312,
    localparam int unsigned SLOT_W = $clog2(max_u(NTSC_SHORT + 1, PAL_SLOTS) + 1),
    localparam int unsigned LINE_W = $clog2(max_u(NTSC_LINES, PAL_LINES) + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              pal_sel,
    input  logic              lace_sel,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [LINE_W-1:0] line_idx,
    output logic              line_end,
    output logic              frame_end,
    output logic              field_odd,
    output logic              line_long
);

    logic pal_act;

    beam_hcount #(
        .NTSC_SHORT(NTSC_SHORT),
        .PAL_SLOTS (PAL_SLOTS),
        .W         (SLOT_W)
    ) i_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .pal_act   (pal_act),
        .frame_wrap(frame_end),
        .slot      (slot_idx),
        .eol       (line_end),
        .long_now  (line_long)
    );

    beam_vcount #(
        .NTSC_LINES(NTSC_LINES),
        .PAL_LINES (PAL_LINES),
        .W         (LINE_W)
    ) i_vcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .eol     (line_end),
        .pal_sel (pal_sel),
        .lace_sel(lace_sel),
        .line    (line_idx),
        .eof     (frame_end),
        .field   (field_odd),
        .pal_act (pal_act)
    );

    p_strobe_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_end && slot_en);
    p_strobe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |-> !line_end);

endmodule

// File: tb/test_beam_slot_counter.sv
module test_beam_slot_counter;

    localparam int NS = 7;
    localparam int PS = 6;
    localparam int NL = 5;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_en = 1'b0;
    logic pal_sel = 1'b0;
    logic lace_sel = 1'b0;
    logic [3:0] slot_idx;
    logic [2:0] line_idx;
    logic line_end, frame_end, field_odd, line_long;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_slot, m_line, m_long, m_field, m_pal, m_lace;

    always #5 clk = ~clk;

    beam_slot_counter #(
        .NTSC_SHORT(NS), .PAL_SLOTS(PS), .NTSC_LINES(NL), .PAL_LINES(PL)
    ) i_beam_slot_counter (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
        .pal_sel(pal_sel), .lace_sel(lace_sel),
        .slot_idx(slot_idx), .line_idx(line_idx),
        .line_end(line_end), .frame_end(frame_end),
        .field_odd(field_odd), .line_long(line_long)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int slot_len();
        if (m_pal) return PS;
        return m_long ? NS + 1 : NS;
    endfunction

    function automatic int frame_len();
        return (m_pal ? PL : NL) + ((m_lace && m_field) ? 1 : 0);
    endfunction

    task automatic step(input bit en, input bit pal, input bit lace);
        bit e_eol, e_eof;
        @(negedge clk);
        slot_en  = en;
        pal_sel  = pal;
        lace_sel = lace;
        #1;
        e_eol = en && (m_slot == slot_len() - 1);
        e_eof = e_eol && (m_line == frame_len() - 1);
        check("R2 slot", int'(slot_idx), m_slot);
        check((pal != m_pal || lace != m_lace) ? "R8 line_end" : "R3 line_end",
              int'(line_end), int'(e_eol));
        check("R6 line", int'(line_idx), m_line);
        check("R6 frame_end", int'(frame_end), int'(e_eof));
        check("R7 field", int'(field_odd), m_field);
        check(m_pal ? "R5 line_long" : "R4 line_long", int'(line_long), m_long);
        if (en) begin
            if (e_eol) begin
                m_slot = 0;
                if (e_eof) begin
                    m_line  = 0;
                    m_long  = 0;
                    m_field = m_lace ? 1 - m_field : 0;
                    m_pal   = pal;
                    m_lace  = lace;
                end else begin
                    m_line++;
                    m_long = 1 - m_long;
                end
            end else begin
                m_slot++;
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_slot = 0; m_line = 0; m_long = 0; m_field = 0; m_pal = 0; m_lace = 0;
        #22;
        check("R1 slot", int'(slot_idx), 0);
        check("R1 line", int'(line_idx), 0);
        check("R1 field", int'(field_odd), 0);
        check("R1 line_long", int'(line_long), 0);
        rst_n = 1'b1;
        // 60 Hz progressive, continuous enable (R4, R6)
        for (int i = 0; i < 150; i++) step(1'b1, 1'b0, 1'b0);
        // gaps in enable, including on final slots (R2)
        for (int i = 0; i < 200; i++) step((i % 3) != 1, 1'b0, 1'b0);
        // request 50 Hz in mid-frame (R8, R5)
        for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b0);
        // interlace at 50 Hz (R7)
        for (int i = 0; i < 300; i++) step((i % 5) != 4, 1'b1, 1'b1);
        // interlace at 60 Hz
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b1);
        // drop interlace, toggle mode requests every cycle (R8)
        for (int i = 0; i < 300; i++) step((i % 4) != 0, (i % 2) == 0, (i % 7) == 0);
        for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule